// File: doc/BRIEF.md
# Barrel Shifter with Shifter Carry

This block is the operand shifter of a 32-bit data path. It takes a data word and returns it shifted or rotated in one of five ways. The shift amount runs from 0 to 31, except for the one-bit rotate through carry. Beside the shifted word it returns the last bit pushed off the end of the word. That bit becomes the new C flag when a move or logical operation that sets flags uses a shifted second operand.

The block is purely combinational and holds no state. Shift amounts of 32 or more are not handled. Immediate rotation decoding is not done here, and neither is flag storage. The caller presents the current carry flag on `carry_in`. That value is passed through for a zero shift and enters the top bit during the rotate through carry.

Top module: `barrel_shifter`

## Requirements
- R1: With `shift_kind` = 0 (left shift), `data_out` is `data_in` moved up by `shift_amt` bit positions, and zeros fill the vacated low bits.
- R2: With `shift_kind` = 1 (logical right shift), `data_out` is `data_in` moved down by `shift_amt` positions, and zeros fill the vacated high bits.
- R3: With `shift_kind` = 2 (arithmetic right shift), `data_out` is `data_in` moved down by `shift_amt` positions, and copies of `data_in[31]` fill the vacated high bits.
- R4: With `shift_kind` = 3 (rotate right), `data_out` is `data_in` rotated down by `shift_amt` positions, so bits leaving bit 0 re-enter at bit 31.
- R5: With `shift_kind` = 4 (rotate right through carry), `data_out` is {`carry_in`, `data_in[31:1]`} and `carry_out` is `data_in[0]`, whatever the value of `shift_amt`.
- R6: For a left shift by n with 1 ≤ n ≤ 31, `carry_out` is `data_in[32-n]`.
- R7: For a logical right shift, arithmetic right shift or rotate right by n with 1 ≤ n ≤ 31, `carry_out` is `data_in[n-1]`.
- R8: For `shift_kind` 0 to 3 with `shift_amt` = 0, `data_out` equals `data_in` and `carry_out` equals `carry_in`.
- R9: For the unused `shift_kind` codes 5, 6 and 7, `data_out` equals `data_in` and `carry_out` equals `carry_in`.
- R10: The outputs are a combinational function of the present inputs, with no clock and no stored state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_in | input | 32 | Word to be shifted |
| shift_kind | input | 3 | Operation: 0 left, 1 logical right, 2 arithmetic right, 3 rotate right, 4 rotate through carry |
| shift_amt | input | 5 | Shift distance, 0 to 31 (ignored for rotate through carry) |
| carry_in | input | 1 | Current carry flag |
| data_out | output | 32 | Shifted word |
| carry_out | output | 1 | Last bit shifted out, or `carry_in` when nothing leaves the word |

## Verification
Both results, `data_out` and `carry_out`, are due in the same cycle as the inputs that produce them, because no register lies between input and output. The bench changes the inputs just after a rising clock edge. It reads the outputs at the following falling edge, half a period later, so every value has settled before it is compared. The clock only paces the stimulus. All four right and left shift kinds are swept over every amount from 0 to 31, and the rotate through carry is run with several amounts to show that `shift_amt` has no effect on it.

// File: rtl/barrel_shifter.sv
`timescale 1ns/1ps
module barrel_shifter #(
  parameter int WIDTH = 32,
  localparam int AW = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] data_in,
  input  logic [2:0]       shift_kind,
  input  logic [AW-1:0]    shift_amt,
  input  logic             carry_in,
  output logic [WIDTH-1:0] data_out,
  output logic             carry_out
);
  localparam logic [2:0] K_LSL = 3'd0;
  localparam logic [2:0] K_LSR = 3'd1;
  localparam logic [2:0] K_ASR = 3'd2;
  localparam logic [2:0] K_ROR = 3'd3;
  localparam logic [2:0] K_RRX = 3'd4;

  logic is_left, is_arith, is_rot;
  assign is_left  = (shift_kind == K_LSL);
  assign is_arith = (shift_kind == K_ASR);
  assign is_rot   = (shift_kind == K_ROR);

  logic [WIDTH-1:0] flipped_in, core_word, flipped_out;
  logic [WIDTH:0]   stage [0:AW];

  for (genvar i = 0; i < WIDTH; i++) begin : g_flip
    assign flipped_in[i]  = data_in[WIDTH-1-i];
    assign flipped_out[i] = core_word[WIDTH-1-i];
  end

  // bit 0 of each stage holds the most recent bit pushed out of the word
  assign stage[0] = {(is_left ? flipped_in : data_in), carry_in};

  for (genvar k = 0; k < AW; k++) begin : g_stage
    localparam int S = 1 << k;
    logic           fill;
    logic [WIDTH:0] moved;
    assign fill  = is_arith & stage[k][WIDTH];
    assign moved = is_rot ? {stage[k][S:1], stage[k][WIDTH:S]}
                          : {{S{fill}}, stage[k][WIDTH:S]};
    assign stage[k+1] = shift_amt[k] ? moved : stage[k];
  end

  assign core_word = stage[AW][WIDTH:1];

  always_comb begin
    data_out  = data_in;
    carry_out = carry_in;
    case (shift_kind)
      K_LSL: begin
        data_out  = flipped_out;
        carry_out = stage[AW][0];
      end
      K_LSR, K_ASR, K_ROR: begin
        data_out  = core_word;
        carry_out = stage[AW][0];
      end
      K_RRX: begin
        data_out  = {carry_in, data_in[WIDTH-1:1]};
        carry_out = data_in[0];
      end
      default: ;
    endcase
  end
endmodule

module barrel_shifter_chk #(
  parameter int WIDTH = 32,
  localparam int AW = $clog2(WIDTH)
) (
  input logic [WIDTH-1:0] data_in,
  input logic [2:0]       shift_kind,
  input logic [AW-1:0]    shift_amt,
  input logic             carry_in,
  input logic [WIDTH-1:0] data_out,
  input logic             carry_out
);
  int n;
  assign n = int'(shift_amt);

  always_comb begin
    if (shift_kind <= 3'd3 && shift_amt == '0) begin
      p_zero_pass_r8: assert (data_out == data_in && carry_out == carry_in)
        else $error("zero-distance shift altered word or carry");
    end
    if (shift_kind >= 3'd5) begin
      p_unused_pass_r9: assert (data_out == data_in && carry_out == carry_in)
        else $error("unused kind altered word or carry");
    end
    if (shift_kind == 3'd4) begin
      p_rrx_top_r5: assert (data_out[WIDTH-1] == carry_in && carry_out == data_in[0])
        else $error("rotate through carry mismatch");
    end
    if (shift_kind == 3'd0 && n != 0) begin
      p_lsl_low_zero_r1: assert (data_out[0] == 1'b0)
        else $error("left shift left a one in bit 0");
      p_lsl_carry_r6: assert (carry_out == data_in[WIDTH-n])
        else $error("left shift carry mismatch");
    end
    if (shift_kind == 3'd1 && n != 0) begin
      p_lsr_top_zero_r2: assert (data_out[WIDTH-1] == 1'b0)
        else $error("logical right shift left a one in the top bit");
    end
    if (shift_kind == 3'd2) begin
      p_asr_sign_r3: assert (data_out[WIDTH-1] == data_in[WIDTH-1])
        else $error("arithmetic right shift lost the sign");
    end
    if (shift_kind == 3'd3) begin
      p_ror_ones_r4: assert ($countones(data_out) == $countones(data_in))
        else $error("rotate changed the number of ones");
    end
    if (shift_kind >= 3'd1 && shift_kind <= 3'd3 && n != 0) begin
      p_right_carry_r7: assert (carry_out == data_in[n-1])
        else $error("right shift carry mismatch");
    end
  end
endmodule

bind barrel_shifter barrel_shifter_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/barrel_shifter_bench.sv
`timescale 1ns/1ps
module barrel_shifter_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [31:0] data_in, data_out;
  logic [2:0]  shift_kind;
  logic [4:0]  shift_amt;
  logic        carry_in, carry_out;

  barrel_shifter u_barrel_shifter (
    .data_in(data_in), .shift_kind(shift_kind), .shift_amt(shift_amt),
    .carry_in(carry_in), .data_out(data_out), .carry_out(carry_out)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct packed {
    logic [7:0]  req;
    logic [2:0]  kind;
    logic [4:0]  amt;
    logic        cin;
    logic [31:0] din;
    logic [31:0] eout;
    logic        ecout;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{8'd1, 3'd0, 5'd4,  1'b0, 32'h0000_0001, 32'h0000_0010, 1'b0}, // R1 R6
    '{8'd6, 3'd0, 5'd1,  1'b0, 32'h8000_0001, 32'h0000_0002, 1'b1}, // R6
    '{8'd6, 3'd0, 5'd4,  1'b0, 32'hF000_0000, 32'h0000_0000, 1'b1}, // R6
    '{8'd7, 3'd1, 5'd1,  1'b0, 32'h0000_0003, 32'h0000_0001, 1'b1}, // R2 R7
    '{8'd2, 3'd1, 5'd31, 1'b1, 32'h8000_0000, 32'h0000_0001, 1'b0}, // R2
    '{8'd3, 3'd2, 5'd4,  1'b0, 32'h8000_0000, 32'hF800_0000, 1'b0}, // R3
    '{8'd7, 3'd2, 5'd5,  1'b0, 32'h7000_0010, 32'h0380_0000, 1'b1}, // R3 R7
    '{8'd3, 3'd2, 5'd31, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1}, // R3
    '{8'd4, 3'd3, 5'd1,  1'b0, 32'h0000_0001, 32'h8000_0000, 1'b1}, // R4 R7
    '{8'd4, 3'd3, 5'd8,  1'b0, 32'h1234_5678, 32'h7812_3456, 1'b0}, // R4
    '{8'd5, 3'd4, 5'd17, 1'b1, 32'h0000_0003, 32'h8000_0001, 1'b1}, // R5
    '{8'd5, 3'd4, 5'd0,  1'b0, 32'h8000_0002, 32'h4000_0001, 1'b0}, // R5
    '{8'd8, 3'd1, 5'd0,  1'b1, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 1'b1}, // R8
    '{8'd9, 3'd6, 5'd3,  1'b0, 32'h1234_5678, 32'h1234_5678, 1'b0}  // R9
  };

  function automatic logic [32:0] model(input logic [2:0] k, input int a,
                                        input logic c, input logic [31:0] d);
    logic [31:0] o = d;
    logic co = c;
    case (k)
      3'd0: begin
        for (int i = 0; i < 32; i++) o[i] = (i >= a) ? d[i-a] : 1'b0;
        if (a != 0) co = d[32-a];
      end
      3'd1, 3'd2: begin
        for (int i = 0; i < 32; i++)
          o[i] = (i + a < 32) ? d[i+a] : ((k == 3'd2) ? d[31] : 1'b0);
        if (a != 0) co = d[a-1];
      end
      3'd3: begin
        for (int i = 0; i < 32; i++) o[i] = d[(i+a)%32];
        if (a != 0) co = d[a-1];
      end
      3'd4: begin
        o = {c, d[31:1]};
        co = d[0];
      end
      default: ;
    endcase
    return {co, o};
  endfunction

  task automatic apply_check(input int req, input logic [2:0] k, input logic [4:0] a,
                             input logic c, input logic [31:0] d,
                             input logic [31:0] eo, input logic ec);
    @(posedge clk);
    #1;
    data_in = d; shift_kind = k; shift_amt = a; carry_in = c;
    @(negedge clk);
    checks++;
    if (data_out !== eo || carry_out !== ec) begin
      failures++;
      $display("FAIL R%0d kind=%0d amt=%0d din=%h: got out=%h cout=%b, expected out=%h cout=%b",
               req, k, a, d, data_out, carry_out, eo, ec);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL R10 watchdog expired: got no completion, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  localparam logic [31:0] PATS [4] = '{32'h8000_0001, 32'hA5C3_0F96, 32'h7FFF_FFFE, 32'h0001_8000};

  initial begin
    logic [32:0] exp_v;
    data_in = '0; shift_kind = '0; shift_amt = '0; carry_in = 1'b0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    checks++; // R10: all-zero inputs give all-zero outputs with no history
    if (data_out !== 32'h0 || carry_out !== 1'b0) begin
      failures++;
      $display("FAIL R10 idle: got out=%h cout=%b, expected out=00000000 cout=0", data_out, carry_out);
    end

    for (int v = 0; v < NV; v++)
      apply_check(int'(VECS[v].req), VECS[v].kind, VECS[v].amt, VECS[v].cin,
                  VECS[v].din, VECS[v].eout, VECS[v].ecout);

    // sweep of R1 R2 R3 R4 R6 R7 R8 over every distance
    for (int p = 0; p < 4; p++)
      for (int k = 0; k < 4; k++)
        for (int a = 0; a < 32; a++) begin
          logic c = logic'((p + a) % 2);
          exp_v = model(3'(k), a, c, PATS[p]);
          apply_check((a == 0) ? 8 : k + 1, 3'(k), 5'(a), c, PATS[p], exp_v[31:0], exp_v[32]);
        end

    // R5: distance has no effect on rotate through carry
    for (int a = 0; a < 32; a += 5) begin
      exp_v = model(3'd4, 0, 1'b1, 32'hC000_0004);
      apply_check(5, 3'd4, 5'(a), 1'b1, 32'hC000_0004, exp_v[31:0], exp_v[32]);
    end

    // R9: each unused code
    for (int k = 5; k < 8; k++)
      apply_check(9, 3'(k), 5'd9, 1'b1, 32'h0F0F_1234, 32'h0F0F_1234, 1'b1);

    // R10: output follows an input change with no clock edge in between
    data_in = 32'h0000_0100; shift_kind = 3'd1; shift_amt = 5'd8; carry_in = 1'b0;
    #1;
    checks++;
    if (data_out !== 32'h0000_0001 || carry_out !== 1'b0) begin
      failures++;
      $display("FAIL R10 comb: got out=%h cout=%b, expected out=00000001 cout=0", data_out, carry_out);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule